// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block turns pending exception requests into the register-file writes that enter an exception handler, and it also performs the matching return. While it is idle, it picks the most urgent request that is not masked. Interrupt requests are masked by the current status word. It then snapshots the current status and instruction address, and plays out a fixed three-step sequence:

1. It writes the pre-entry status into the banked saved-status register of the target mode.
2. It writes the adjusted return address into that mode's banked link register.
3. In a single cycle, it writes the new status word and loads the program counter with the vector address.

A return request runs a shorter sequence. It writes the supplied saved status back as the current status and the supplied link value into the program counter, both in one cycle. The block only drives write strobes and data. The status register and banked register file that receive them lie outside it, as do instruction execution and memory. The vector table sits either at address zero or at a high base, chosen by a configuration input that is sampled when a request is accepted.

Top module: `exc_ctrl`

## Requirements
- R1: Request bits in `exc_req` are: bit0 reset, bit1 undefined instruction, bit2 software interrupt, bit3 prefetch abort, bit4 data abort, bit5 normal interrupt, bit6 fast interrupt. When several requests are accepted together, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R2: The PC written on entry is the base plus an offset. The base is 0, or 0xFFFF0000 when `hi_vec` was 1 at acceptance. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: In the cycle after an entry is accepted, `bank_status_we` is 1. `bank_status_data` equals `cur_status` at acceptance, and `bank_status_mode` holds the target mode code. The mode codes are: 0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for both aborts, 0x12 for normal interrupt and 0x11 for fast interrupt.
- R4: In the second cycle after acceptance, `link_we` is 1 and `link_mode` is the target mode. `link_data` is `inst_addr` at acceptance plus 8 for data abort, plus 0 for reset, and plus 4 for every other exception.
- R5: In the third cycle after acceptance, `status_we` and `pc_we` are both 1. The new status keeps all bits of the snapshot except these: bits [4:0] become the target mode, bit 5 (instruction-state) is cleared, bit 7 (normal-interrupt mask) is set, and bit 6 (fast-interrupt mask) is set for reset and fast interrupt and otherwise kept.
- R6: A normal interrupt request is ignored while `cur_status` bit 7 is 1, and a fast interrupt request is ignored while bit 6 is 1.
- R7: Requests and input values that change after acceptance, and before the sequence completes, have no effect on that sequence.
- R8: If `ret_req` is 1 in an idle cycle with no entry accepted, the next cycle has `status_we` = `pc_we` = 1, with `status_data` = `ret_status` and `pc_data` = `ret_link`, and no banked writes. When an entry is accepted in the same cycle as a return request, the entry wins.
- R9: While `rst_n` is low, `busy` and all write strobes are 0.
- R10: `busy` is 1 from the cycle after acceptance through the last strobe cycle, and 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 7 | Pending exception requests (bit map in R1) |
| hi_vec | input | 1 | Select high vector base |
| cur_status | input | STAT_W | Current status word |
| inst_addr | input | ADDR_W | Address of the faulting or next instruction |
| ret_req | input | 1 | Request a return from exception |
| ret_status | input | STAT_W | Saved status of the current mode for return |
| ret_link | input | ADDR_W | Link register of the current mode for return |
| busy | output | 1 | Sequence in progress |
| bank_status_we | output | 1 | Saved-status bank write strobe |
| bank_status_mode | output | 5 | Mode whose saved status is written |
| bank_status_data | output | STAT_W | Saved-status write data |
| link_we | output | 1 | Banked link register write strobe |
| link_mode | output | 5 | Mode whose link register is written |
| link_data | output | ADDR_W | Link write data |
| status_we | output | 1 | Current status write strobe |
| status_data | output | STAT_W | Current status write data |
| pc_we | output | 1 | Program counter write strobe |
| pc_data | output | ADDR_W | Program counter write data |

## Verification
The bench builds the block with its defaults: a 32-bit address and status word, and the high-vector option enabled. With these values, both vector bases are reachable from a single input. The full-width status word lets the bench confirm that bits outside the mode, state and mask fields pass through entry unchanged. Random request mixes and random mask states drive the priority and masking paths. During busy cycles the bench deliberately disturbs the inputs, so that stale-latch faults show up in the link and vector data.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

   localparam int REQ_N  = 7;
   localparam int MODE_W = 5;

   // status word field positions
   localparam int ST_T = 5;
   localparam int ST_F = 6;
   localparam int ST_I = 7;

   localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
   localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
   localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
   localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
   localparam logic [MODE_W-1:0] MD_UND = 5'h1B;

   typedef enum logic [2:0] {
      EK_RESET = 3'd0,
      EK_UNDEF = 3'd1,
      EK_SWI   = 3'd2,
      EK_PABT  = 3'd3,
      EK_DABT  = 3'd4,
      EK_IRQ   = 3'd5,
      EK_FIQ   = 3'd6
   } exc_kind_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_SAVE,
      SQ_LINK,
      SQ_SWITCH,
      SQ_RETURN
   } seq_state_e;

   typedef struct packed {
      logic [MODE_W-1:0] mode;
      logic [4:0]        vec_off;
      logic [3:0]        link_off;
      logic              set_f;
   } exc_attr_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_ctrl_pkg::*;
(
   input  logic [REQ_N-1:0] req,
   input  logic             mask_i,
   input  logic             mask_f,
   output logic             valid,
   output exc_kind_e        kind
);

   always_comb begin
      valid = 1'b1;
      kind  = EK_RESET;
      if (req[EK_RESET])                 kind = EK_RESET;
      else if (req[EK_DABT])             kind = EK_DABT;
      else if (req[EK_FIQ] && !mask_f)   kind = EK_FIQ;
      else if (req[EK_IRQ] && !mask_i)   kind = EK_IRQ;
      else if (req[EK_PABT])             kind = EK_PABT;
      else if (req[EK_UNDEF])            kind = EK_UNDEF;
      else if (req[EK_SWI])              kind = EK_SWI;
      else                               valid = 1'b0;
   end

endmodule

// File: rtl/exc_attr_map.sv
module exc_attr_map
   import exc_ctrl_pkg::*;
#(
   parameter int              ADDR_W      = 32,
   parameter bit              HIGH_VEC_EN = 1'b1,
   parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
)(
   input  exc_kind_e         kind,
   input  logic              hi_sel,
   output exc_attr_t         attr,
   output logic [ADDR_W-1:0] vec_addr
);

   logic [ADDR_W-1:0] base;

   generate
      if (HIGH_VEC_EN) begin : g_hi_base
         assign base = hi_sel ? HIGH_BASE : '0;
      end else begin : g_lo_base
         logic unused_hi;
         assign unused_hi = hi_sel;
         assign base      = '0;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         EK_RESET: attr = '{mode: MD_SVC, vec_off: 5'h00, link_off: 4'd0, set_f: 1'b1};
         EK_UNDEF: attr = '{mode: MD_UND, vec_off: 5'h04, link_off: 4'd4, set_f: 1'b0};
         EK_SWI:   attr = '{mode: MD_SVC, vec_off: 5'h08, link_off: 4'd4, set_f: 1'b0};
         EK_PABT:  attr = '{mode: MD_ABT, vec_off: 5'h0C, link_off: 4'd4, set_f: 1'b0};
         EK_DABT:  attr = '{mode: MD_ABT, vec_off: 5'h10, link_off: 4'd8, set_f: 1'b0};
         EK_IRQ:   attr = '{mode: MD_IRQ, vec_off: 5'h18, link_off: 4'd4, set_f: 1'b0};
         EK_FIQ:   attr = '{mode: MD_FIQ, vec_off: 5'h1C, link_off: 4'd4, set_f: 1'b1};
         default:  attr = '{mode: MD_SVC, vec_off: 5'h14, link_off: 4'd0, set_f: 1'b1};
      endcase
   end

   assign vec_addr = base + {{(ADDR_W-5){1'b0}}, attr.vec_off};

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_ctrl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STAT_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  exc_kind_e         req_kind,
   input  logic              hi_vec,
   input  logic [STAT_W-1:0] cur_status,
   input  logic [ADDR_W-1:0] inst_addr,
   input  logic              ret_req,
   input  logic [STAT_W-1:0] ret_status,
   input  logic [ADDR_W-1:0] ret_link,
   input  exc_attr_t         attr,
   input  logic [ADDR_W-1:0] vec_addr,
   output exc_kind_e         kind_q,
   output logic              hi_q,
   output logic              busy,
   output logic              bank_status_we,
   output logic [MODE_W-1:0] bank_status_mode,
   output logic [STAT_W-1:0] bank_status_data,
   output logic              link_we,
   output logic [MODE_W-1:0] link_mode,
   output logic [ADDR_W-1:0] link_data,
   output logic              status_we,
   output logic [STAT_W-1:0] status_data,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_data
);

   seq_state_e        state;
   logic [STAT_W-1:0] stat_q;   // entry snapshot or return status
   logic [ADDR_W-1:0] addr_q;   // entry address or return link
   logic [STAT_W-1:0] entry_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         kind_q <= EK_RESET;
         hi_q   <= 1'b0;
         stat_q <= '0;
         addr_q <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (req_valid) begin
                  state  <= SQ_SAVE;
                  kind_q <= req_kind;
                  hi_q   <= hi_vec;
                  stat_q <= cur_status;
                  addr_q <= inst_addr;
               end else if (ret_req) begin
                  state  <= SQ_RETURN;
                  stat_q <= ret_status;
                  addr_q <= ret_link;
               end
            end
            SQ_SAVE:   state <= SQ_LINK;
            SQ_LINK:   state <= SQ_SWITCH;
            SQ_SWITCH: state <= SQ_IDLE;
            SQ_RETURN: state <= SQ_IDLE;
            default:   state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      entry_status            = stat_q;
      entry_status[MODE_W-1:0] = attr.mode;
      entry_status[ST_T]      = 1'b0;
      entry_status[ST_I]      = 1'b1;
      entry_status[ST_F]      = stat_q[ST_F] | attr.set_f;
   end

   assign busy             = (state != SQ_IDLE);
   assign bank_status_we   = (state == SQ_SAVE);
   assign bank_status_mode = attr.mode;
   assign bank_status_data = stat_q;
   assign link_we          = (state == SQ_LINK);
   assign link_mode        = attr.mode;
   assign link_data        = addr_q + {{(ADDR_W-4){1'b0}}, attr.link_off};
   assign status_we        = (state == SQ_SWITCH) || (state == SQ_RETURN);
   assign pc_we            = status_we;
   assign status_data      = (state == SQ_SWITCH) ? entry_status : stat_q;
   assign pc_data          = (state == SQ_SWITCH) ? vec_addr : addr_q;

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
   import exc_ctrl_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                STAT_W      = 32,
   parameter bit                HIGH_VEC_EN = 1'b1,
   parameter logic [ADDR_W-1:0] HIGH_BASE   = 32'hFFFF_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        exc_req,
   input  logic              hi_vec,
   input  logic [STAT_W-1:0] cur_status,
   input  logic [ADDR_W-1:0] inst_addr,
   input  logic              ret_req,
   input  logic [STAT_W-1:0] ret_status,
   input  logic [ADDR_W-1:0] ret_link,
   output logic              busy,
   output logic              bank_status_we,
   output logic [4:0]        bank_status_mode,
   output logic [STAT_W-1:0] bank_status_data,
   output logic              link_we,
   output logic [4:0]        link_mode,
   output logic [ADDR_W-1:0] link_data,
   output logic              status_we,
   output logic [STAT_W-1:0] status_data,
   output logic              pc_we,
   output logic [ADDR_W-1:0] pc_data
);

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("exc_ctrl: ADDR_W must be at least 16");
      end
      if (STAT_W < 8) begin : g_bad_stat
         $error("exc_ctrl: STAT_W must hold mode, state and mask fields");
      end
      if (HIGH_BASE[4:0] != 5'd0) begin : g_bad_base
         $error("exc_ctrl: HIGH_BASE must be aligned to the vector table");
      end
   endgenerate

   logic              arb_valid;
   exc_kind_e         arb_kind;
   exc_kind_e         kind_q;
   logic              hi_q;
   exc_attr_t         attr;
   logic [ADDR_W-1:0] vec_addr;

   exc_arbiter u_arb (
      .req    (exc_req),
      .mask_i (cur_status[ST_I]),
      .mask_f (cur_status[ST_F]),
      .valid  (arb_valid),
      .kind   (arb_kind)
   );

   exc_attr_map #(
      .ADDR_W      (ADDR_W),
      .HIGH_VEC_EN (HIGH_VEC_EN),
      .HIGH_BASE   (HIGH_BASE)
   ) u_map (
      .kind     (kind_q),
      .hi_sel   (hi_q),
      .attr     (attr),
      .vec_addr (vec_addr)
   );

   exc_seq #(
      .ADDR_W (ADDR_W),
      .STAT_W (STAT_W)
   ) u_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .req_valid        (arb_valid),
      .req_kind         (arb_kind),
      .hi_vec           (hi_vec),
      .cur_status       (cur_status),
      .inst_addr        (inst_addr),
      .ret_req          (ret_req),
      .ret_status       (ret_status),
      .ret_link         (ret_link),
      .attr             (attr),
      .vec_addr         (vec_addr),
      .kind_q           (kind_q),
      .hi_q             (hi_q),
      .busy             (busy),
      .bank_status_we   (bank_status_we),
      .bank_status_mode (bank_status_mode),
      .bank_status_data (bank_status_data),
      .link_we          (link_we),
      .link_mode        (link_mode),
      .link_data        (link_data),
      .status_we        (status_we),
      .status_data      (status_data),
      .pc_we            (pc_we),
      .pc_data          (pc_data)
   );

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
   parameter int                ADDR_W    = 32,
   parameter int                STAT_W    = 32,
   parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000
)(
   input logic              clk,
   input logic              rst_n,
   input logic [6:0]        exc_req,
   input logic [STAT_W-1:0] cur_status,
   input logic              ret_req,
   input logic              busy,
   input logic              bank_status_we,
   input logic [STAT_W-1:0] bank_status_data,
   input logic              link_we,
   input logic              status_we,
   input logic [STAT_W-1:0] status_data,
   input logic              pc_we,
   input logic [ADDR_W-1:0] pc_data
);

   // strobes never overlap; status and pc always move together
   assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bank_status_we, link_we, status_we}) && (status_we == pc_we));

   assert_save_then_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_status_we |=> link_we);

   assert_link_then_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> (status_we && pc_we));

   assert_entry_status_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we && $past(link_we)) |-> (!status_data[5] && status_data[7]));

   assert_vector_in_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && $past(link_we)) |->
         (pc_data[1:0] == 2'b00 &&
          (pc_data[ADDR_W-1:5] == '0 || pc_data[ADDR_W-1:5] == HIGH_BASE[ADDR_W-1:5])));

   assert_snapshot_saved_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bank_status_we |-> (bank_status_data == $past(cur_status)));

   assert_masked_irq_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && exc_req == 7'b010_0000 && cur_status[7] && !ret_req) |=> !busy);

   assert_idle_after_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      status_we |=> !busy);

endmodule

bind exc_ctrl exc_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .STAT_W    (STAT_W),
   .HIGH_BASE (HIGH_BASE)
) u_chk (.*);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  exc_req = '0;
   logic        hi_vec = 1'b0;
   logic [31:0] cur_status = '0;
   logic [31:0] inst_addr = '0;
   logic        ret_req = 1'b0;
   logic [31:0] ret_status = '0;
   logic [31:0] ret_link = '0;
   logic        busy;
   logic        bank_status_we;
   logic [4:0]  bank_status_mode;
   logic [31:0] bank_status_data;
   logic        link_we;
   logic [4:0]  link_mode;
   logic [31:0] link_data;
   logic        status_we;
   logic [31:0] status_data;
   logic        pc_we;
   logic [31:0] pc_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   exc_ctrl dut (.*);

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   function automatic int ref_kind(input logic [6:0] rq, input logic [31:0] st);
      if (rq[0])               return 0;
      if (rq[4])               return 4;
      if (rq[6] && !st[6])     return 6;
      if (rq[5] && !st[7])     return 5;
      if (rq[3])               return 3;
      if (rq[1])               return 1;
      if (rq[2])               return 2;
      return -1;
   endfunction

   function automatic logic [31:0] ref_off(input int k);
      case (k)
         0: return 32'h00;  1: return 32'h04;  2: return 32'h08;
         3: return 32'h0C;  4: return 32'h10;  5: return 32'h18;
         default: return 32'h1C;
      endcase
   endfunction

   function automatic logic [4:0] ref_mode(input int k);
      case (k)
         0, 2:    return 5'h13;
         1:       return 5'h1B;
         3, 4:    return 5'h17;
         5:       return 5'h12;
         default: return 5'h11;
      endcase
   endfunction

   function automatic logic [31:0] ref_link(input int k);
      if (k == 0) return 32'd0;
      if (k == 4) return 32'd8;
      return 32'd4;
   endfunction

   function automatic logic [31:0] ref_status(input int k, input logic [31:0] st);
      logic [31:0] r;
      r = st;
      r[4:0] = ref_mode(k);
      r[5] = 1'b0;
      r[7] = 1'b1;
      if (k == 0 || k == 6) r[6] = 1'b1;
      return r;
   endfunction

   task automatic clear_inputs();
      exc_req = '0; ret_req = 1'b0; hi_vec = 1'b0;
      cur_status = 32'h0000_00C0; inst_addr = '0;
      ret_status = '0; ret_link = '0;
   endtask

   task automatic disturb();
      exc_req    = 7'($urandom);
      ret_req    = 1'b1;
      hi_vec     = ~hi_vec;
      cur_status = $urandom;
      inst_addr  = $urandom;
      ret_status = $urandom;
      ret_link   = $urandom;
   endtask

   // one operation: drive, then follow the sequence at negative edges
   task automatic run_op(input logic [6:0] rq, input logic [31:0] st, input logic [31:0] ad,
                         input logic hv, input logic rr, input logic [31:0] rs,
                         input logic [31:0] rl, input bit junk, input string tag);
      int k;
      logic [31:0] base;
      @(negedge clk);
      exc_req = rq; cur_status = st; inst_addr = ad; hi_vec = hv;
      ret_req = rr; ret_status = rs; ret_link = rl;
      k = ref_kind(rq, st);
      base = hv ? 32'hFFFF_0000 : 32'h0;
      @(negedge clk);
      if (k >= 0) begin
         chk({31'd0, busy}, 32'd1, {tag, " R10 busy after accept"});
         chk({31'd0, bank_status_we}, 32'd1, {tag, " R3 save strobe"});
         chk(bank_status_data, st, {tag, " R3 saved status"});
         chk({27'd0, bank_status_mode}, {27'd0, ref_mode(k)}, {tag, " R1 R3 save mode"});
         if (junk) disturb();
         @(negedge clk);
         chk({31'd0, link_we}, 32'd1, {tag, " R4 link strobe"});
         chk({27'd0, link_mode}, {27'd0, ref_mode(k)}, {tag, " R4 link mode"});
         chk(link_data, ad + ref_link(k), {tag, " R4 R7 link data"});
         chk({31'd0, status_we}, 32'd0, {tag, " R4 no status write yet"});
         if (junk) disturb();
         @(negedge clk);
         chk({30'd0, status_we, pc_we}, 32'd3, {tag, " R5 switch strobes"});
         chk(status_data, ref_status(k, st), {tag, " R5 new status"});
         chk(pc_data, base + ref_off(k), {tag, " R1 R2 vector"});
         clear_inputs();
         @(negedge clk);
         chk({31'd0, busy}, 32'd0, {tag, " R10 idle after sequence"});
      end else if (rr) begin
         chk({29'd0, bank_status_we, link_we, status_we && pc_we}, 32'd1, {tag, " R8 return strobes"});
         chk(status_data, rs, {tag, " R8 restored status"});
         chk(pc_data, rl, {tag, " R8 restored pc"});
         clear_inputs();
         @(negedge clk);
         chk({31'd0, busy}, 32'd0, {tag, " R8 idle after return"});
      end else begin
         chk({28'd0, busy, bank_status_we, link_we, status_we}, 32'd0, {tag, " R6 request ignored"});
         clear_inputs();
      end
   endtask

   initial begin
      void'($urandom(32'd7341));
      clear_inputs();
      repeat (3) @(negedge clk);
      chk({27'd0, busy, bank_status_we, link_we, status_we, pc_we}, 32'd0, "R9 reset state");
      exc_req = 7'h7F;
      @(negedge clk);
      chk({27'd0, busy, bank_status_we, link_we, status_we, pc_we}, 32'd0, "R9 requests held in reset");
      exc_req = '0;
      rst_n = 1'b1;

      // directed corner cases
      run_op(7'h7F, 32'h0000_0010, 32'h0000_1000, 1'b0, 1'b1, 32'h1, 32'h2, 1'b0, "R1 all requests");
      run_op(7'h7E, 32'h0000_0010, 32'h0000_2000, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, "R1 dabt over fiq");
      run_op(7'h60, 32'h0000_0050, 32'h0000_3000, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, "R6 fiq masked irq taken");
      run_op(7'h20, 32'h0000_0090, 32'h0000_4000, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, "R6 irq masked");
      run_op(7'h40, 32'h0000_0050, 32'h0000_4000, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, "R6 fiq masked");
      run_op(7'h06, 32'hF000_0030, 32'h0000_5004, 1'b1, 1'b0, 32'h0, 32'h0, 1'b1, "R7 undef over swi");
      run_op(7'h04, 32'h0000_001F, 32'h8000_0000, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, "R2 swi high base");
      run_op(7'h00, 32'h0000_0012, 32'h0, 1'b0, 1'b1, 32'hA000_0030, 32'h0000_7778, 1'b0, "R8 return");
      run_op(7'h08, 32'h0000_0010, 32'h0000_9000, 1'b0, 1'b1, 32'h5, 32'h6, 1'b0, "R8 entry beats return");

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [6:0]  rq;
         logic [31:0] st;
         rq = 7'($urandom) & 7'($urandom);
         if (($urandom % 8) == 0) rq = '0;
         st = $urandom;
         run_op(rq, st, {$urandom} & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
                $urandom, $urandom, 1'($urandom), "R1 R2 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule